// File: doc/BRIEF.md
# Data-Processing Execute Unit

This block is the execute stage for the integer data-processing part of a 64-bit load/store instruction set. Decode and register read happen upstream, so every operand arrives already read: a first operand, a second register operand, a third addend, a 12-bit arithmetic immediate and a 16-bit move immediate. From these the unit computes one destination value and a write enable. It also keeps the four condition flags (negative, zero, carry, overflow) as registered state. A single width bit selects 64-bit or 32-bit operation. In 32-bit mode every operand is cut to its low half, every result is zero-extended, and bit 31 is the sign used for flags.

The second register operand goes through a four-way barrel shifter and then an optional bitwise inversion before it reaches the adder or the logic operators. A wide-move path places a 16-bit immediate in one of the 16-bit lanes of the destination. A multiply path adds a product to the addend or subtracts it from the addend.

Requests enter on a valid/ready handshake and leave through a single registered output slot with its own valid/ready pair. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output slot is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the slot holds its contents and no new request is accepted. The flags update on the edge that accepts a flag-setting request.

Top module: `dp_exec_unit`

## Requirements
- R1: A request accepted on an edge shows up on `result`, `wr_en` and `err`, with `out_valid` high, after that same edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the output fields stay unchanged and `in_ready` stays low.
- R2: When `wide` is 0, operands are truncated to 32 bits, the result's upper 32 bits are zero, flags use bit 31 as the sign, and the carry is taken out of bit 31.
- R3: For arithmetic codes 0 ADD, 1 ADDS, 2 SUB and 3 SUBS with `use_imm`=1, the second operand is the zero-extended 12-bit `arith_imm`. It is shifted left by 12 when `imm_hi` is 1. In that case the shifter and the inversion are bypassed.
- R4: The register second operand is shifted by `sh_amt` according to `sh_kind`: 0 logical left, 1 logical right, 2 arithmetic right (sign from bit 63 or bit 31), 3 rotate right. In 32-bit mode only `sh_amt[4:0]` is used. Logic codes are 4 AND, 5 OR, 6 XOR and 7 flag-setting AND, and they always use the register operand.
- R5: Rotate-right on a register-operand arithmetic code (0 to 3), and any code from 13 to 15, sets `err`, clears `wr_en`, gives `result` 0 and leaves the flags unchanged.
- R6: When `inv_b` is 1, the shifted register operand is bitwise inverted (within the selected width) before use.
- R7: ADDS sets the flags `nzcv` (bit 3 N, bit 2 Z, bit 1 C, bit 0 V) as follows: N is the result sign; Z is set for a zero result; C is the unsigned carry out of the width; V is set when both operands have equal signs and the result sign differs from them.
- R8: SUBS sets N and Z the same way. C is set when the first operand is unsigned greater than or equal to the second. V is set when the operand signs differ and the result sign equals the second operand's sign.
- R9: Code 7 sets N and Z from the result and clears C and V. All other codes leave `nzcv` unchanged.
- R10: Wide move places `mv_imm` at bit 16*`mv_lane`. Code 8 writes its inverse, code 9 writes it alone, and code 10 replaces only that lane of `opa`, keeping the other bits.
- R11: When `wide` is 0, a wide move with `mv_lane` above 1 sets `err`, clears `wr_en` and gives `result` 0.
- R12: Code 11 gives `opc + opa*opb` and code 12 gives `opc - opa*opb`, truncated to the width.
- R13: A synchronous active-high `rst` clears `nzcv` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| op | input | 4 | Operation code |
| wide | input | 1 | 1 = 64-bit, 0 = 32-bit |
| opa | input | 64 | First operand; old destination for lane keep |
| opb | input | 64 | Second register operand |
| opc | input | 64 | Addend for multiply |
| arith_imm | input | 12 | Arithmetic immediate |
| imm_hi | input | 1 | Shift the immediate left by 12 |
| use_imm | input | 1 | Arithmetic uses the immediate |
| sh_kind | input | 2 | Shift type of the register operand |
| sh_amt | input | 6 | Shift amount |
| inv_b | input | 1 | Invert the shifted register operand |
| mv_imm | input | 16 | Wide-move immediate |
| mv_lane | input | 2 | Wide-move 16-bit lane index |
| out_valid | output | 1 | Output slot holds a result |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 64 | Destination value |
| wr_en | output | 1 | Destination should be written |
| err | output | 1 | Illegal request |
| nzcv | output | 4 | Condition flags N, Z, C, V |

## Verification
The bench targets the flag edges where widths and signs meet. Signed overflow at 0x7FFF... + 1 would show a missing V if the sign bit were taken from the wrong position. A 32-bit add of 0xFFFFFFFF + 1 with nonzero upper input bits would give a nonzero result or a lost carry if truncation came after the sum instead of before it. A 32-bit subtract of 0x80000000 - 1 would show a wrong V if bit 63 were used as the sign. A flag-setting AND that follows a subtract with C and V set would expose C or V left stale. The shifter cases cover a 64-bit arithmetic shift by 63 that must fill with ones, a 32-bit rotate with amount 33 that must wrap to 1, and inversion that must come after the shift and not before. A rotate on a subtract must leave the flags untouched. A 32-bit lane-2 move must be refused. Back-pressure checks that a held result does not change while the next request waits.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDS = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBS = 4'd3,
    OP_AND  = 4'd4,
    OP_ORR  = 4'd5,
    OP_EOR  = 4'd6,
    OP_ANDS = 4'd7,
    OP_MOVN = 4'd8,
    OP_MOVZ = 4'd9,
    OP_MOVK = 4'd10,
    OP_MADD = 4'd11,
    OP_MSUB = 4'd12
  } dpx_op_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } dpx_shift_e;

  typedef enum logic [1:0] {
    MV_NOT  = 2'd0,
    MV_ZERO = 2'd1,
    MV_KEEP = 2'd2
  } dpx_mv_e;
endpackage

// File: rtl/dpx_shifter.sv
module dpx_shifter
  import dpx_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0]         val,
  input  logic                  wide,
  input  dpx_shift_e            kind,
  input  logic [$clog2(DW)-1:0] amt,
  input  logic                  inv,
  output logic [DW-1:0]         y
);
  localparam int HW = DW / 2;
  localparam int AW = $clog2(DW);

  logic [DW-1:0] full;
  logic [HW-1:0] half;
  logic [HW-1:0] vh;
  logic [AW-2:0] amt_h;

  // Both width variants are built side by side; the width bit picks one.
  always_comb begin
    vh    = val[HW-1:0];
    amt_h = amt[AW-2:0];
    case (kind)
      SH_LSL: begin
        full = val << amt;
        half = vh << amt_h;
      end
      SH_LSR: begin
        full = val >> amt;
        half = vh >> amt_h;
      end
      SH_ASR: begin
        full = $unsigned($signed(val) >>> amt);
        half = $unsigned($signed(vh) >>> amt_h);
      end
      default: begin
        full = (val >> amt) | (val << (DW - int'(amt)));
        half = (vh >> amt_h) | (vh << (HW - int'(amt_h)));
      end
    endcase
    if (wide) y = inv ? ~full : full;
    else      y = {{HW{1'b0}}, (inv ? ~half : half)};
  end
endmodule

// File: rtl/dpx_addsub.sv
module dpx_addsub #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  input  logic          wide,
  output logic [DW-1:0] sum,
  output logic          cout,
  output logic          ovf
);
  localparam int HW = DW / 2;

  logic [DW-1:0] bx;
  logic [DW:0]   sf;
  logic [HW:0]   sh;

  // Subtraction is a + ~b + 1, so carry out doubles as "no borrow".
  always_comb begin
    bx = sub ? ~b : b;
    sf = {1'b0, a} + {1'b0, bx} + {{DW{1'b0}}, sub};
    sh = {1'b0, a[HW-1:0]} + {1'b0, bx[HW-1:0]} + {{HW{1'b0}}, sub};
    if (wide) begin
      sum  = sf[DW-1:0];
      cout = sf[DW];
      ovf  = (a[DW-1] == bx[DW-1]) && (sf[DW-1] != a[DW-1]);
    end else begin
      sum  = {{HW{1'b0}}, sh[HW-1:0]};
      cout = sh[HW];
      ovf  = (a[HW-1] == bx[HW-1]) && (sh[HW-1] != a[HW-1]);
    end
  end
endmodule

// File: rtl/dpx_widemove.sv
module dpx_widemove
  import dpx_pkg::*;
#(
  parameter int DW = 64,
  parameter int LW = 16,
  localparam int LB = $clog2(DW / LW)
) (
  input  logic [LW-1:0] imm,
  input  logic [LB-1:0] lane,
  input  dpx_mv_e       kind,
  input  logic [DW-1:0] old,
  input  logic          wide,
  output logic [DW-1:0] res,
  output logic          bad
);
  localparam int HW = DW / 2;

  logic [DW-1:0] placed;
  logic [DW-1:0] lane_mask;
  logic [DW-1:0] raw;

  always_comb begin
    placed    = DW'(imm) << (int'(lane) * LW);
    lane_mask = DW'({LW{1'b1}}) << (int'(lane) * LW);
    case (kind)
      MV_NOT:  raw = ~placed;
      MV_ZERO: raw = placed;
      default: raw = (old & ~lane_mask) | placed;
    endcase
    res = wide ? raw : {{HW{1'b0}}, raw[HW-1:0]};
    bad = !wide && (int'(lane) >= HW / LW);
  end
endmodule

// File: rtl/dpx_mac.sv
module dpx_mac #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] c,
  input  logic          neg,
  input  logic          wide,
  output logic [DW-1:0] res
);
  localparam int HW = DW / 2;

  logic [DW-1:0] prod;
  logic [DW-1:0] acc;

  always_comb begin
    prod = a * b;
    acc  = neg ? (c - prod) : (c + prod);
    res  = wide ? acc : {{HW{1'b0}}, acc[HW-1:0]};
  end
endmodule

// File: rtl/dp_exec_unit.sv
module dp_exec_unit
  import dpx_pkg::*;
#(
  parameter int DW     = 64,
  parameter int IMM_W  = 12,
  parameter int IMM_SH = 12,
  parameter int LW     = 16,
  localparam int AW    = $clog2(DW),
  localparam int LB    = $clog2(DW / LW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       op,
  input  logic             wide,
  input  logic [DW-1:0]    opa,
  input  logic [DW-1:0]    opb,
  input  logic [DW-1:0]    opc,
  input  logic [IMM_W-1:0] arith_imm,
  input  logic             imm_hi,
  input  logic             use_imm,
  input  logic [1:0]       sh_kind,
  input  logic [AW-1:0]    sh_amt,
  input  logic             inv_b,
  input  logic [LW-1:0]    mv_imm,
  input  logic [LB-1:0]    mv_lane,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    result,
  output logic             wr_en,
  output logic             err,
  output logic [3:0]       nzcv
);
  localparam int HW = DW / 2;

  function automatic logic [DW-1:0] trunc(input logic [DW-1:0] x, input logic w);
    return w ? x : {{HW{1'b0}}, x[HW-1:0]};
  endfunction

  dpx_op_e       opx;
  logic [DW-1:0] a_m, b_m, c_m, imm_ext, sh_y, as_b, as_sum, mv_res, mac_res;
  logic          as_sub, as_c, as_v, mv_bad;
  dpx_mv_e       mv_kind;

  logic [DW-1:0] nx_res;
  logic          nx_err, nx_upd;
  logic [3:0]    nx_fl;
  logic          fire;

  logic          out_valid_q, wr_q, err_q;
  logic [DW-1:0] res_q;
  logic [3:0]    nzcv_q;

  always_comb begin
    opx     = dpx_op_e'(op);
    a_m     = trunc(opa, wide);
    b_m     = trunc(opb, wide);
    c_m     = trunc(opc, wide);
    imm_ext = trunc(DW'(arith_imm) << (imm_hi ? IMM_SH : 0), wide);
    as_b    = use_imm ? imm_ext : sh_y;
    as_sub  = (opx == OP_SUB) || (opx == OP_SUBS);
    case (opx)
      OP_MOVN: mv_kind = MV_NOT;
      OP_MOVZ: mv_kind = MV_ZERO;
      default: mv_kind = MV_KEEP;
    endcase
  end

  dpx_shifter #(.DW(DW)) u_shift (
    .val(b_m), .wide(wide), .kind(dpx_shift_e'(sh_kind)), .amt(sh_amt),
    .inv(inv_b), .y(sh_y)
  );

  dpx_addsub #(.DW(DW)) u_addsub (
    .a(a_m), .b(as_b), .sub(as_sub), .wide(wide),
    .sum(as_sum), .cout(as_c), .ovf(as_v)
  );

  dpx_widemove #(.DW(DW), .LW(LW)) u_move (
    .imm(mv_imm), .lane(mv_lane), .kind(mv_kind), .old(a_m), .wide(wide),
    .res(mv_res), .bad(mv_bad)
  );

  dpx_mac #(.DW(DW)) u_mac (
    .a(a_m), .b(b_m), .c(c_m), .neg(opx == OP_MSUB), .wide(wide), .res(mac_res)
  );

  function automatic logic sign_of(input logic [DW-1:0] x, input logic w);
    return w ? x[DW-1] : x[HW-1];
  endfunction

  // Result select and per-operation flag rules.
  always_comb begin
    nx_res = '0;
    nx_err = 1'b0;
    nx_upd = 1'b0;
    nx_fl  = 4'b0000;
    case (opx)
      OP_ADD, OP_ADDS, OP_SUB, OP_SUBS: begin
        if (!use_imm && dpx_shift_e'(sh_kind) == SH_ROR) begin
          nx_err = 1'b1;
        end else begin
          nx_res = as_sum;
          nx_upd = (opx == OP_ADDS) || (opx == OP_SUBS);
          nx_fl  = {sign_of(as_sum, wide), as_sum == '0, as_c, as_v};
        end
      end
      OP_AND:  nx_res = a_m & sh_y;
      OP_ORR:  nx_res = a_m | sh_y;
      OP_EOR:  nx_res = a_m ^ sh_y;
      OP_ANDS: begin
        nx_res = a_m & sh_y;
        nx_upd = 1'b1;
        nx_fl  = {sign_of(a_m & sh_y, wide), (a_m & sh_y) == '0, 2'b00};
      end
      OP_MOVN, OP_MOVZ, OP_MOVK: begin
        if (mv_bad) nx_err = 1'b1;
        else        nx_res = mv_res;
      end
      OP_MADD, OP_MSUB: nx_res = mac_res;
      default: nx_err = 1'b1;
    endcase
  end

  assign in_ready = !out_valid_q || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_q <= 1'b0;
      res_q       <= '0;
      wr_q        <= 1'b0;
      err_q       <= 1'b0;
      nzcv_q      <= 4'b0000;
    end else begin
      if (fire) begin
        out_valid_q <= 1'b1;
        res_q       <= nx_res;
        wr_q        <= !nx_err;
        err_q       <= nx_err;
        if (nx_upd) nzcv_q <= nx_fl;
      end else if (out_ready) begin
        out_valid_q <= 1'b0;
      end
    end
  end

  assign out_valid = out_valid_q;
  assign result    = res_q;
  assign wr_en     = wr_q;
  assign err       = err_q;
  assign nzcv      = nzcv_q;
endmodule

// File: rtl/dp_exec_chk.sv
module dp_exec_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [3:0]    op,
  input logic          wide,
  input logic          use_imm,
  input logic [1:0]    sh_kind,
  input logic [1:0]    mv_lane,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] result,
  input logic          wr_en,
  input logic          err,
  input logic [3:0]    nzcv
);
  logic fire;
  assign fire = in_valid && in_ready;

  // R1
  hold_slot_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(result) && $stable(wr_en) && $stable(err));

  // R9
  flags_kept_chk: assert property (@(posedge clk) disable iff (rst)
    !(fire && (op == 4'd1 || op == 4'd3 || op == 4'd7)) |=> $stable(nzcv));

  // R9
  and_cv_clear_chk: assert property (@(posedge clk) disable iff (rst)
    fire && op == 4'd7 |=> nzcv[1:0] == 2'b00);

  // R2
  narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
    fire && !wide |=> result[DW-1:DW/2] == '0);

  // R11
  narrow_lane_chk: assert property (@(posedge clk) disable iff (rst)
    fire && !wide && (op == 4'd8 || op == 4'd9 || op == 4'd10) && mv_lane > 2'd1
    |=> err && !wr_en && result == '0);

  // R5
  rotate_arith_chk: assert property (@(posedge clk) disable iff (rst)
    fire && op <= 4'd3 && !use_imm && sh_kind == 2'd3 |=> err && !wr_en && $stable(nzcv));
endmodule

bind dp_exec_unit dp_exec_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .op(op),
  .wide(wide), .use_imm(use_imm), .sh_kind(sh_kind), .mv_lane(mv_lane),
  .out_valid(out_valid), .out_ready(out_ready), .result(result),
  .wr_en(wr_en), .err(err), .nzcv(nzcv)
);

// File: tb/sim_dp_exec_unit.sv
module sim_dp_exec_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [3:0]  op;
  logic        wide, imm_hi, use_imm, inv_b;
  logic [63:0] opa, opb, opc, result;
  logic [11:0] arith_imm;
  logic [1:0]  sh_kind, mv_lane;
  logic [5:0]  sh_amt;
  logic [15:0] mv_imm;
  logic        wr_en, err;
  logic [3:0]  nzcv;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dp_exec_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .op(op),
    .wide(wide), .opa(opa), .opb(opb), .opc(opc), .arith_imm(arith_imm),
    .imm_hi(imm_hi), .use_imm(use_imm), .sh_kind(sh_kind), .sh_amt(sh_amt),
    .inv_b(inv_b), .mv_imm(mv_imm), .mv_lane(mv_lane), .out_valid(out_valid),
    .out_ready(out_ready), .result(result), .wr_en(wr_en), .err(err), .nzcv(nzcv)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Reference: returns {err, flags, result}
  function automatic logic [68:0] ref_op(
    input logic [3:0] o, input logic w, input logic [63:0] a0, b0, c0,
    input logic [11:0] im, input logic ih, ui, input logic [1:0] sk,
    input logic [5:0] sa, input logic iv, input logic [15:0] mi,
    input logic [1:0] ml, input logic [3:0] fl);
    logic [63:0] m, a, b, c, s, bo, r, pv;
    logic [64:0] t;
    logic e, cy, ov;
    logic [3:0] f;
    int amt, wd, sb;
    m = w ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    wd = w ? 64 : 32;
    sb = wd - 1;
    a = a0 & m; b = b0 & m; c = c0 & m;
    amt = w ? int'(sa) : int'(sa) & 31;
    case (sk)
      2'd0: s = (b << amt) & m;
      2'd1: s = b >> amt;
      2'd2: if (w) s = $unsigned($signed(b) >>> amt);
            else   s = $unsigned($signed({{32{b[31]}}, b[31:0]}) >>> amt) & m;
      default: s = (amt == 0) ? b : (((b >> amt) | (b << (wd - amt))) & m);
    endcase
    if (iv) s = ~s & m;
    e = 1'b0; f = fl; r = '0;
    case (o)
      4'd0, 4'd1, 4'd2, 4'd3: begin
        bo = ui ? ((64'(im) << (ih ? 12 : 0)) & m) : s;
        if (!ui && sk == 2'd3) e = 1'b1;
        else begin
          if (o < 4'd2) begin
            r = (a + bo) & m;
            t = 65'(a) + 65'(bo);
            cy = w ? t[64] : t[32];
            ov = (a[sb] == bo[sb]) && (r[sb] != a[sb]);
          end else begin
            r = (a - bo) & m;
            cy = a >= bo;
            ov = (a[sb] != bo[sb]) && (r[sb] == bo[sb]);
          end
          if (o == 4'd1 || o == 4'd3) f = {r[sb], r == 64'd0, cy, ov};
        end
      end
      4'd4: r = a & s;
      4'd5: r = a | s;
      4'd6: r = a ^ s;
      4'd7: begin r = a & s; f = {r[sb], r == 64'd0, 2'b00}; end
      4'd8, 4'd9, 4'd10: begin
        if (!w && ml > 2'd1) e = 1'b1;
        else begin
          pv = 64'(mi) << (int'(ml) * 16);
          if (o == 4'd8)      r = ~pv & m;
          else if (o == 4'd9) r = pv & m;
          else                r = ((a & ~(64'hFFFF << (int'(ml) * 16))) | pv) & m;
        end
      end
      4'd11: r = (c + a * b) & m;
      4'd12: r = (c - a * b) & m;
      default: e = 1'b1;
    endcase
    if (e) begin r = '0; f = fl; end
    return {e, f, r};
  endfunction

  function automatic string tag_of(input logic [3:0] o, input logic w, input logic [1:0] ml);
    case (o)
      4'd0, 4'd2: return "R3";
      4'd1: return "R7";
      4'd3: return "R8";
      4'd4, 4'd5, 4'd6: return "R4";
      4'd7: return "R9";
      4'd8, 4'd9, 4'd10: return (!w && ml > 2'd1) ? "R11" : "R10";
      4'd11, 4'd12: return "R12";
      default: return "R5";
    endcase
  endfunction

  task automatic prep(input logic [3:0] o, input logic w, input logic [63:0] a, input logic [63:0] b);
    op = o; wide = w; opa = a; opb = b; opc = '0; arith_imm = '0; imm_hi = 0;
    use_imm = 0; sh_kind = 2'd0; sh_amt = '0; inv_b = 0; mv_imm = '0; mv_lane = '0;
  endtask

  task automatic issue();
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic dir(input string tag, input logic [63:0] er, input logic [3:0] ef, input logic ee);
    issue();
    chk({out_valid, err, wr_en, nzcv, result} === {1'b1, ee, !ee, ef, er}, tag,
        128'({out_valid, err, wr_en, nzcv, result}), 128'({1'b1, ee, !ee, ef, er}));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [68:0] exp;
    logic [63:0] hold;
    rst = 1; in_valid = 0; out_ready = 1;
    prep(4'd0, 1'b1, '0, '0);
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(nzcv === 4'b0 && out_valid === 1'b0 && in_ready === 1'b1, "R13 reset",
        128'({nzcv, out_valid, in_ready}), 128'({4'b0, 1'b0, 1'b1}));
    rst = 0;
    @(negedge clk);

    // R7 add flags
    prep(4'd1, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1);
    dir("R7 signed overflow", 64'h8000_0000_0000_0000, 4'b1001, 0);
    prep(4'd1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
    dir("R7 carry zero", 64'd0, 4'b0110, 0);
    // R2 32-bit add ignores upper bits
    prep(4'd1, 0, 64'h1234_5678_FFFF_FFFF, 64'hABCD_0000_0000_0001);
    dir("R2 narrow add", 64'd0, 4'b0110, 0);
    // R8 subtract flags
    prep(4'd3, 1, 64'd5, 64'd5);
    dir("R8 equal", 64'd0, 4'b0110, 0);
    prep(4'd3, 1, 64'd0, 64'd1);
    dir("R8 borrow", 64'hFFFF_FFFF_FFFF_FFFF, 4'b1000, 0);
    prep(4'd3, 0, 64'h8000_0000, 64'd1);
    dir("R8 narrow overflow", 64'h7FFF_FFFF, 4'b0011, 0);
    // R9 flag-setting AND clears C and V
    prep(4'd7, 1, 64'hF000_0000_0000_0000, 64'hF000_0000_0000_00FF);
    dir("R9 ands", 64'hF000_0000_0000_0000, 4'b1000, 0);
    prep(4'd0, 1, 64'd1, 64'd2);
    dir("R9 plain add keeps flags", 64'd3, 4'b1000, 0);
    // R3 immediates
    prep(4'd0, 1, 64'h10, 64'hFFFF);
    use_imm = 1; arith_imm = 12'hABC; imm_hi = 1; sh_kind = 2'd3; inv_b = 1;
    dir("R3 shifted imm", 64'hABC010, 4'b1000, 0);
    prep(4'd2, 1, 64'h1000, 64'd0);
    use_imm = 1; arith_imm = 12'hFFF;
    dir("R3 plain imm sub", 64'h1, 4'b1000, 0);
    // R4 shifter
    prep(4'd5, 0, 64'd0, 64'h8000_0000);
    sh_kind = 2'd2; sh_amt = 6'd4;
    dir("R4 narrow asr", 64'hF800_0000, 4'b1000, 0);
    prep(4'd5, 1, 64'd0, 64'h8000_0000_0000_0000);
    sh_kind = 2'd2; sh_amt = 6'd63;
    dir("R4 wide asr", 64'hFFFF_FFFF_FFFF_FFFF, 4'b1000, 0);
    prep(4'd6, 1, 64'd0, 64'd1);
    sh_kind = 2'd3; sh_amt = 6'd1;
    dir("R4 wide ror", 64'h8000_0000_0000_0000, 4'b1000, 0);
    prep(4'd5, 0, 64'd0, 64'd1);
    sh_kind = 2'd3; sh_amt = 6'd33;
    dir("R4 narrow ror wraps", 64'h8000_0000, 4'b1000, 0);
    // R6 inversion after shift
    prep(4'd5, 1, 64'd0, 64'hF0);
    sh_amt = 6'd4; inv_b = 1;
    dir("R6 invert after lsl", 64'hFFFF_FFFF_FFFF_F0FF, 4'b1000, 0);
    prep(4'd4, 0, 64'hFF, 64'h0F);
    inv_b = 1;
    dir("R6 bic narrow", 64'hF0, 4'b1000, 0);
    // R5 illegal requests
    prep(4'd3, 1, 64'd9, 64'd1);
    sh_kind = 2'd3;
    dir("R5 ror on subs", 64'd0, 4'b1000, 1);
    prep(4'd15, 1, 64'd9, 64'd1);
    dir("R5 unknown code", 64'd0, 4'b1000, 1);
    // R10 wide moves
    prep(4'd10, 1, 64'h1111_2222_3333_4444, 64'd0);
    mv_imm = 16'hBEEF; mv_lane = 2'd2;
    dir("R10 keep lane", 64'h1111_BEEF_3333_4444, 4'b1000, 0);
    prep(4'd8, 0, 64'd0, 64'd0);
    mv_imm = 16'h0001; mv_lane = 2'd1;
    dir("R10 not narrow", 64'hFFFE_FFFF, 4'b1000, 0);
    prep(4'd9, 1, 64'hFFFF, 64'd0);
    mv_imm = 16'hABCD; mv_lane = 2'd3;
    dir("R10 zero top lane", 64'hABCD_0000_0000_0000, 4'b1000, 0);
    // R11 narrow lane out of range
    prep(4'd9, 0, 64'd0, 64'd0);
    mv_imm = 16'h1234; mv_lane = 2'd2;
    dir("R11 narrow lane 2", 64'd0, 4'b1000, 1);
    // R12 multiply
    prep(4'd11, 1, 64'd3, 64'd4); opc = 64'd10;
    dir("R12 madd", 64'd22, 4'b1000, 0);
    prep(4'd12, 1, 64'd3, 64'd4); opc = 64'd10;
    dir("R12 msub", 64'hFFFF_FFFF_FFFF_FFFE, 4'b1000, 0);
    prep(4'd12, 0, 64'h1_0000_0003, 64'd4); opc = 64'd10;
    dir("R12 msub narrow", 64'hFFFF_FFFE, 4'b1000, 0);

    // R1 back-pressure
    @(negedge clk);
    out_ready = 0;
    prep(4'd0, 1, 64'd5, 64'd6);
    issue();
    chk(out_valid === 1 && result === 64'd11 && in_ready === 0, "R1 accept then stall",
        128'({out_valid, in_ready, result}), 128'({1'b1, 1'b0, 64'd11}));
    hold = result;
    prep(4'd0, 1, 64'd1, 64'd1);
    in_valid = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid === 1 && result === hold && in_ready === 0, "R1 held while stalled",
          128'({out_valid, in_ready, result}), 128'({1'b1, 1'b0, hold}));
    end
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk(out_valid === 1 && result === 64'd2, "R1 waiting request taken after drain",
        128'({out_valid, result}), 128'({1'b1, 64'd2}));

    // Random phase against the reference function
    void'($urandom(32'd20240611));
    for (int k = 0; k < 600; k++) begin
      int pick;
      op = 4'($urandom_range(0, 15));
      wide = 1'($urandom_range(0, 1));
      pick = $urandom_range(0, 5);
      opa = (pick == 0) ? 64'd0 : (pick == 1) ? 64'hFFFF_FFFF_FFFF_FFFF :
            (pick == 2) ? 64'h8000_0000_8000_0000 : {$urandom, $urandom};
      opb = ($urandom_range(0, 4) == 0) ? opa : {$urandom, $urandom};
      opc = {$urandom, $urandom};
      arith_imm = 12'($urandom); imm_hi = 1'($urandom_range(0, 1));
      use_imm = 1'($urandom_range(0, 1)); sh_kind = 2'($urandom_range(0, 3));
      sh_amt = 6'($urandom_range(0, 63)); inv_b = 1'($urandom_range(0, 1));
      mv_imm = 16'($urandom); mv_lane = 2'($urandom_range(0, 3));
      exp = ref_op(op, wide, opa, opb, opc, arith_imm, imm_hi, use_imm, sh_kind,
                   sh_amt, inv_b, mv_imm, mv_lane, nzcv);
      issue();
      chk({err, wr_en, nzcv, result} === {exp[68], !exp[68], exp[67:64], exp[63:0]},
          tag_of(op, wide, mv_lane),
          128'({err, wr_en, nzcv, result}), 128'({exp[68], !exp[68], exp[67:64], exp[63:0]}));
    end

    // R13 reset clears flags after activity
    prep(4'd3, 1, 64'd0, 64'd1);
    issue();
    rst = 1;
    @(negedge clk);
    chk(nzcv === 4'b0 && out_valid === 0, "R13 reset after use",
        128'({nzcv, out_valid}), 128'({4'b0, 1'b0}));
    rst = 0;
    @(negedge clk);

    summary();
    $finish;
  end
endmodule